// File: doc/BRIEF.md
# Parallel Flash Programming Target Interface

This block is the device-side logic through which an external programmer writes, reads back and erases a 1024-byte on-chip code store over a parallel byte port. No address bus is present. An internal counter clears on the rising edge of the control line `ctl_rst_i` and steps by one on each rising pulse of `step_i`. The programmer selects an operation on four mode lines, then pulses the active-low strobe.

Byte writes and lock-bit writes time themselves. The ready flag drops while a write is in flight. During that time, a read of the byte being written returns its top bit inverted, so the programmer can poll for completion. A chip erase is accepted only when the strobe is held low for a long, parameterised time. Two lock bits block code readback. A signature mode returns fixed identification bytes. The store is a register array, and programming enable is a single digital input.

All inputs are sampled on `clk_i`. Edges of `ctl_rst_i`, `step_i` and `strobe_ni` are detected on the clock edge at which the new level is first sampled.

Top module: `pflash_prog_target`

## Requirements
- R1: After `rst_ni` is released, `rdy_o` is 1, both lock bits are clear and every location reads back 8'hFF.
- R2: On the clock edge that first samples `ctl_rst_i` high after a low, the address counter becomes 0. On the edge that first samples `step_i` high after a low, it advances by one. It wraps from 1023 to 0, and a clear takes priority over a step.
- R3: The edge that first samples `strobe_ni` high after a low starts a write when all of these hold: `ctl_rst_i`=1, `prog_en_i`=1, the block is idle and `mode_i`=4'b1110. `rdy_o` is 0 from that edge for exactly WRITE_CYCLES cycles and then returns to 1, with the data latched at the start stored at the latched address.
- R4: While a code write is in flight, a code read (`mode_i`=4'b0110) of the address being written returns the latched data with bit 7 inverted. After completion it returns the true byte.
- R5: A code write to a location whose content is not 8'hFF leaves that location unchanged, although the timed busy period still runs.
- R6: With `mode_i`=4'b1000, `ctl_rst_i`=1, `prog_en_i`=1 and the block idle, holding `strobe_ni` low for ERASE_CYCLES consecutive sampled cycles sets every location to 8'hFF and clears both lock bits. A shorter hold changes nothing.
- R7: In signature mode (`mode_i`=4'b0000) with `ctl_rst_i`=1, addresses 0, 1 and 2 return 8'h1E, 8'h12 and SIG2 (default 8'h3C). Other addresses return 8'hFF. Lock bits do not affect this mode.
- R8: Modes 4'b1111 and 4'b1100 program lock bit 1 and lock bit 2 with the same timing as R3. While either lock bit is set, a code read returns 8'hFF.
- R9: While `rdy_o` is 0, strobe pulses are ignored. A strobe with `prog_en_i`=0, or with a mode code other than the five listed in R3, R6 and R8, starts nothing: `rdy_o` stays 1 and the store is unchanged.
- R10: `data_oe_o` is 1 only when `ctl_rst_i`=1 and `mode_i` is 4'b0110 or 4'b0000. Otherwise `data_o` idles at 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_rst_i | input | 1 | Interface enable; its rising edge clears the address counter |
| prog_en_i | input | 1 | Programming enable for write, lock and erase operations |
| step_i | input | 1 | Address step pulse |
| strobe_ni | input | 1 | Active-low program strobe |
| mode_i | input | 4 | Operation select |
| data_i | input | 8 | Write data from the programmer |
| data_o | output | 8 | Read data to the programmer |
| data_oe_o | output | 1 | Drive enable for the external data bus |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest state to reach from the ports is a read of the in-flight byte during a write. Reaching it takes three steps: a mode change mid-write to a read code, dropping program enable, and sampling inside the busy window, which is only WRITE_CYCLES long. The bench does this inside every write it issues and compares against the inverted top bit. The bench also places strobe pulses inside the busy window and after locking the device. It holds the erase strobe for exactly one cycle less than the threshold and then for exactly the threshold. Random walks of the counter, mixed with writes to blank and non-blank locations, are checked against a byte-level model held in the bench.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam logic [3:0] MODE_WR_CODE = 4'b1110;
  localparam logic [3:0] MODE_RD_CODE = 4'b0110;
  localparam logic [3:0] MODE_WR_LB1  = 4'b1111;
  localparam logic [3:0] MODE_WR_LB2  = 4'b1100;
  localparam logic [3:0] MODE_ERASE   = 4'b1000;
  localparam logic [3:0] MODE_RD_SIG  = 4'b0000;

  typedef enum logic [1:0] {
    WK_CODE = 2'd0,
    WK_LB1  = 2'd1,
    WK_LB2  = 2'd2
  } wkind_e;
endpackage

// File: rtl/pfp_edge.sv
module pfp_edge #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= RST_VAL[g];
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfp_addr_ctr.sv
module pfp_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + AW'(1);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pfp_store.sv
module pfp_store #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          erase_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pfp_ctrl.sv
module pfp_ctrl
  import pfp_pkg::*;
#(
  parameter int AW           = 10,
  parameter int DW           = 8,
  parameter int WRITE_CYCLES = 14400,
  parameter int ERASE_CYCLES = 120000,
  localparam int TW          = $clog2(WRITE_CYCLES + 1),
  localparam int EW          = $clog2(ERASE_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_i,
  input  logic          prog_en_i,
  input  logic          strobe_ni,
  input  logic          strobe_rise_i,
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          blank_i,
  output logic          busy_o,
  output logic          poll_o,
  output logic [1:0]    lock_o,
  output logic          commit_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o,
  output logic          erase_o
);
  logic          busy_q, wr_ok_q, hold_q, go, done, cmd_ok, ers_arm;
  wkind_e        kind_q, go_kind;
  logic [TW-1:0] tmr_q;
  logic [EW-1:0] ers_cnt_q;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic [1:0]    lock_q;

  assign cmd_ok = ctl_i & prog_en_i & ~busy_q;

  always_comb begin
    go      = 1'b0;
    go_kind = WK_CODE;
    if (cmd_ok && strobe_rise_i) begin
      case (mode_i)
        MODE_WR_CODE: begin go = 1'b1; go_kind = WK_CODE; end
        MODE_WR_LB1:  begin go = 1'b1; go_kind = WK_LB1;  end
        MODE_WR_LB2:  begin go = 1'b1; go_kind = WK_LB2;  end
        default: ;
      endcase
    end
  end

  assign done = busy_q && (tmr_q == '0);

  // self-timed write sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      kind_q    <= WK_CODE;
      tmr_q     <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '1;
      wr_ok_q   <= 1'b0;
    end else if (go) begin
      busy_q    <= 1'b1;
      kind_q    <= go_kind;
      tmr_q     <= TW'(WRITE_CYCLES - 1);
      wr_addr_q <= addr_i;
      wr_data_q <= data_i;
      wr_ok_q   <= blank_i;
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - TW'(1);
    end
  end

  // erase hold timer: restarts whenever the hold is broken
  assign ers_arm = cmd_ok & ~strobe_ni & (mode_i == MODE_ERASE);
  assign erase_o = ers_arm & ~hold_q & (ers_cnt_q == EW'(ERASE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ers_cnt_q <= '0;
      hold_q    <= 1'b0;
    end else if (!ers_arm) begin
      ers_cnt_q <= '0;
      hold_q    <= 1'b0;
    end else if (erase_o) begin
      hold_q    <= 1'b1;
    end else if (!hold_q) begin
      ers_cnt_q <= ers_cnt_q + EW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 2'b00;
    else if (erase_o) lock_q <= 2'b00;
    else if (done) begin
      if (kind_q == WK_LB1) lock_q[0] <= 1'b1;
      if (kind_q == WK_LB2) lock_q[1] <= 1'b1;
    end
  end

  assign busy_o        = busy_q;
  assign poll_o        = busy_q && (kind_q == WK_CODE);
  assign lock_o        = lock_q;
  assign commit_o      = done && (kind_q == WK_CODE) && wr_ok_q;
  assign commit_addr_o = wr_addr_q;
  assign commit_data_o = wr_data_q;
endmodule

// File: rtl/pflash_prog_target.sv
module pflash_prog_target
  import pfp_pkg::*;
#(
  parameter int          DEPTH        = 1024,
  parameter int          DW           = 8,
  parameter int          WRITE_CYCLES = 14400,
  parameter int          ERASE_CYCLES = 120000,
  parameter logic [7:0]  SIG0         = 8'h1E,
  parameter logic [7:0]  SIG1         = 8'h12,
  parameter logic [7:0]  SIG2         = 8'h3C,
  localparam int         AW           = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_rst_i,
  input  logic          prog_en_i,
  input  logic          step_i,
  input  logic          strobe_ni,
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_o
);
  logic [2:0]    rise;
  logic [AW-1:0] ctr_addr, wr_addr;
  logic [DW-1:0] mem_rd, wr_data, rd_byte;
  logic [1:0]    lock_bits;
  logic          busy, poll, commit, erase, rd_code, rd_sig;

  // bit 0: ctl_rst_i, bit 1: step_i, bit 2: strobe_ni (idles high)
  pfp_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({strobe_ni, step_i, ctl_rst_i}),
    .rise_o (rise)
  );

  pfp_addr_ctr #(.AW(AW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rise[0]),
    .inc_i  (rise[1]),
    .addr_o (ctr_addr)
  );

  pfp_ctrl #(
    .AW(AW), .DW(DW), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctl_i         (ctl_rst_i),
    .prog_en_i     (prog_en_i),
    .strobe_ni     (strobe_ni),
    .strobe_rise_i (rise[2]),
    .mode_i        (mode_i),
    .addr_i        (ctr_addr),
    .data_i        (data_i),
    .blank_i       (mem_rd == '1),
    .busy_o        (busy),
    .poll_o        (poll),
    .lock_o        (lock_bits),
    .commit_o      (commit),
    .commit_addr_o (wr_addr),
    .commit_data_o (wr_data),
    .erase_o       (erase)
  );

  pfp_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .erase_i   (erase),
    .rd_addr_i (ctr_addr),
    .rd_data_o (mem_rd)
  );

  assign rd_code = ctl_rst_i && (mode_i == MODE_RD_CODE);
  assign rd_sig  = ctl_rst_i && (mode_i == MODE_RD_SIG);

  always_comb begin
    rd_byte = '1;
    if (rd_sig) begin
      if      (ctr_addr == AW'(0)) rd_byte = DW'(SIG0);
      else if (ctr_addr == AW'(1)) rd_byte = DW'(SIG1);
      else if (ctr_addr == AW'(2)) rd_byte = DW'(SIG2);
    end else if (rd_code && lock_bits == 2'b00) begin
      if (poll && ctr_addr == wr_addr) rd_byte = {~wr_data[DW-1], wr_data[DW-2:0]};
      else                             rd_byte = mem_rd;
    end
  end

  assign data_o    = rd_byte;
  assign data_oe_o = rd_code | rd_sig;
  assign rdy_o     = ~busy;
endmodule

// File: rtl/pflash_prog_target_chk.sv
module pflash_prog_target_chk #(
  parameter int         AW   = 10,
  parameter int         DW   = 8,
  parameter logic [7:0] SIG0 = 8'h1E
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_rst_i,
  input logic          step_i,
  input logic          strobe_ni,
  input logic [3:0]    mode_i,
  input logic [DW-1:0] rd_data_i,
  input logic          data_oe_i,
  input logic          rdy_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    lock_i,
  input logic [AW-1:0] wr_addr_i
);
  assert_ctr_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rst_i && !$past(ctl_rst_i)) |=> (addr_i == '0));

  assert_ctr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !$past(step_i) && !(ctl_rst_i && !$past(ctl_rst_i)))
      |=> (addr_i == $past(addr_i) + AW'(1)));

  assert_busy_after_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_i) |-> ($past(strobe_ni) && !$past(strobe_ni, 2)));

  assert_busy_target_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |=> (rdy_i || $stable(wr_addr_i)));

  assert_locked_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i != 2'b00 && ctl_rst_i && mode_i == 4'b0110) |-> (rd_data_i == '1));

  assert_sig_byte0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rst_i && mode_i == 4'b0000 && addr_i == '0) |-> (rd_data_i == DW'(SIG0)));

  assert_oe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_i |-> (ctl_rst_i && (mode_i == 4'b0110 || mode_i == 4'b0000)));
endmodule

bind pflash_prog_target pflash_prog_target_chk #(.AW(AW), .DW(DW), .SIG0(SIG0)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctl_rst_i (ctl_rst_i),
  .step_i    (step_i),
  .strobe_ni (strobe_ni),
  .mode_i    (mode_i),
  .rd_data_i (data_o),
  .data_oe_i (data_oe_o),
  .rdy_i     (rdy_o),
  .addr_i    (ctr_addr),
  .lock_i    (lock_bits),
  .wr_addr_i (wr_addr)
);

// File: tb/pflash_prog_target_tb.sv
module pflash_prog_target_tb;
  localparam int DEPTH = 1024;
  localparam int WC    = 20;
  localparam int EC    = 50;
  localparam logic [3:0] M_WR = 4'b1110, M_RD = 4'b0110, M_LB1 = 4'b1111,
                         M_LB2 = 4'b1100, M_ER = 4'b1000, M_SIG = 4'b0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ctl, prog_en, step, strobe_n, oe, rdy;
  logic [3:0] mode;
  logic [7:0] din, dout;

  int         n_vec, n_bad, addr_m;
  bit         done_f;
  logic [7:0] mem_m [DEPTH];
  logic [1:0] lock_m;

  pflash_prog_target #(.WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_rst_i(ctl), .prog_en_i(prog_en),
    .step_i(step), .strobe_ni(strobe_n), .mode_i(mode), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .rdy_o(rdy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input int a);
    return (lock_m != 2'b00) ? 8'hFF : mem_m[a];
  endfunction

  task automatic read_chk(input string req);
    mode = M_RD; prog_en = 1'b0; #1;
    check(req, dout, exp_code(addr_m));
  endtask

  task automatic ctr_clear();
    ctl = 1'b0; tick(); ctl = 1'b1; tick();
    addr_m = 0;
  endtask

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin
      step = 1'b1; tick(); step = 1'b0; tick();
      addr_m = (addr_m + 1) % DEPTH;
    end
  endtask

  // timed write of any kind; R3 timing and R4 polling checked inside
  task automatic do_prog(input logic [3:0] m, input logic [7:0] d);
    mode = m; din = d; prog_en = 1'b1; strobe_n = 1'b0; tick();
    strobe_n = 1'b1; tick();
    check("R3 busy on start", {7'b0, rdy}, 8'h00);
    if (m == M_WR) begin
      mode = M_RD; prog_en = 1'b0; #1;
      check("R4 poll in flight", dout, (lock_m != 0) ? 8'hFF : {~d[7], d[6:0]});
      mode = m; prog_en = 1'b1;
    end
    repeat (WC - 1) tick();
    check("R3 busy last cycle", {7'b0, rdy}, 8'h00);
    tick();
    check("R3 ready after write", {7'b0, rdy}, 8'h01);
    if (m == M_WR && mem_m[addr_m] == 8'hFF) mem_m[addr_m] = d;
    if (m == M_LB1) lock_m[0] = 1'b1;
    if (m == M_LB2) lock_m[1] = 1'b1;
  endtask

  task automatic erase_hold(input int n);
    mode = M_ER; prog_en = 1'b1; strobe_n = 1'b0;
    repeat (n) tick();
    strobe_n = 1'b1; tick();
    if (n >= EC) begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
      lock_m = 2'b00;
    end
  endtask

  task automatic sig_chk(input logic [7:0] exp);
    mode = M_SIG; prog_en = 1'b0; #1;
    check("R7 signature", dout, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_f) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int         r;
    n_vec = 0; n_bad = 0; addr_m = 0; lock_m = 2'b00; done_f = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    void'($urandom(32'd1051));
    rst_n = 1'b0; ctl = 1'b0; prog_en = 1'b0; step = 1'b0; strobe_n = 1'b1;
    mode = M_RD; din = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1; tick();

    // R1, R10 reset state
    check("R1 ready after reset", {7'b0, rdy}, 8'h01);
    check("R10 oe off with ctl low", {7'b0, oe}, 8'h00);
    check("R10 idle data", dout, 8'hFF);
    ctr_clear();
    read_chk("R1 blank at 0");
    check("R10 oe on in read", {7'b0, oe}, 8'h01);
    mode = M_WR; #1;
    check("R10 oe off in write mode", {7'b0, oe}, 8'h00);
    step_n(5);
    read_chk("R1 blank at 5");

    // R7 signatures
    ctr_clear();
    sig_chk(8'h1E); step_n(1);
    sig_chk(8'h12); step_n(1);
    sig_chk(8'h3C); step_n(1);
    sig_chk(8'hFF);

    // R3/R4 first write, R5 overwrite attempt
    ctr_clear();
    do_prog(M_WR, 8'h5A);
    read_chk("R3 data stored");
    do_prog(M_WR, 8'h00);
    read_chk("R5 non-blank unchanged");

    // R9 strobe during busy is ignored
    step_n(1);
    mode = M_WR; din = 8'h33; prog_en = 1'b1; strobe_n = 1'b0; tick();
    strobe_n = 1'b1; tick();
    repeat (4) tick();
    din = 8'h00; strobe_n = 1'b0; tick(); strobe_n = 1'b1; tick();
    repeat (WC) tick();
    check("R9 ready after ignored strobe", {7'b0, rdy}, 8'h01);
    mem_m[addr_m] = 8'h33;
    read_chk("R9 busy strobe ignored");

    // R9 unknown mode and disabled programming
    step_n(1);
    mode = 4'b1010; din = 8'h00; prog_en = 1'b1; strobe_n = 1'b0; tick();
    strobe_n = 1'b1; tick();
    check("R9 unknown mode no busy", {7'b0, rdy}, 8'h01);
    read_chk("R9 unknown mode no write");
    mode = M_WR; prog_en = 1'b0; strobe_n = 1'b0; tick();
    strobe_n = 1'b1; tick();
    check("R9 prog_en low no busy", {7'b0, rdy}, 8'h01);
    read_chk("R9 prog_en low no write");

    // random mix checked against the model
    for (int it = 0; it < 120; it++) begin
      r = $urandom_range(0, 9);
      if (r <= 3) begin
        step_n($urandom_range(1, 6));
        read_chk("R2 random step");
      end else if (r <= 6) begin
        held = 8'($urandom_range(0, 255));
        do_prog(M_WR, held);
        read_chk("R5 random write");
      end else if (r == 7) begin
        ctr_clear();
        read_chk("R2 random clear");
      end else begin
        read_chk("R3 random read");
      end
    end

    // R2 counter wrap
    ctr_clear();
    step_n(DEPTH);
    read_chk("R2 wrap to 0");
    check("R2 wrap value", dout, 8'h5A);

    // R8 lock bit 1
    do_prog(M_LB1, 8'h00);
    read_chk("R8 locked read");
    check("R8 locked value", dout, 8'hFF);
    sig_chk(8'h1E);

    // R6 short hold does nothing
    erase_hold(EC - 1);
    read_chk("R6 short hold keeps lock");
    check("R6 still locked", dout, 8'hFF);

    // R6 full erase
    erase_hold(EC);
    read_chk("R6 erased 0");
    check("R6 blank value", dout, 8'hFF);
    step_n(1);
    read_chk("R6 erased 1");
    do_prog(M_WR, 8'hA5);
    read_chk("R6 writable after erase");
    check("R6 lock cleared", dout, 8'hA5);

    // R8 lock bit 2
    do_prog(M_LB2, 8'h00);
    read_chk("R8 lock2 read");
    check("R8 lock2 value", dout, 8'hFF);

    done_f = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule